// File: doc/BRIEF.md
# 8-Bit Accumulator ALU with Nibble Carry

This block is the arithmetic and logic unit of an accumulator-style 8-bit core. One operand is always the working register. The second operand is chosen by a source selector: a file-register value, an immediate literal, or the working register itself. The unit adds, subtracts, rotates through carry, and performs AND, inclusive OR, XOR, complement and pass operations. The result is combinational, so the surrounding core reads it in the same cycle it presents the operands.

The block owns the three status flags: Carry, Digit Carry (the carry across the nibble boundary) and Zero. Each operation drives a per-flag update enable. When `op_valid` is high, the flag register loads the new values on the rising clock edge, but only for the flags whose enable is set. All other flags keep their previous values. Subtraction computes the selected operand minus the working register. It follows the carry-is-not-borrow convention: C and DC read 1 when no borrow occurs. Rotates take the incoming bit from the stored Carry.

The unit has no state machine. Its only state is the three-bit flag register, with two conditions: held and loaded. Decoding instructions and writing the result back are done outside this block.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `flag_c`, `flag_dc` and `flag_z` are 0.
- R2: ADD (op_code 0): result = (W + B) mod 256. The new C is the carry out of bit 7. The new DC is the carry out of bit 3.
- R3: SUB (op_code 1): result = (B − W) mod 256, computed as B + ~W + 1. The new C is 1 when B ≥ W. The new DC is 1 when B[3:0] ≥ W[3:0].
- R4: For every operation that updates Z, the new Z is 1 exactly when the result is 0x00.
- R5: AND (2), IOR (3) and XOR (4) give the bitwise function of W and B. They update Z only.
- R6: COM (5) gives ~B and PASS (6) gives B. Both update Z only.
- R7: RLC (7) gives {B[6:0], C} and RRC (8) gives {C, B[7:1]}. The new C is B[7] for RLC and B[0] for RRC. DC and Z are unchanged.
- R8: `src_sel` picks B: 0 is `f_data`, 1 is `lit_data`, 2 is `w_data`, 3 is `f_data`.
- R9: op_codes 9 to 15 give result 0x00 and assert no update enable. When `op_valid` is low, the flags do not change at all.
- R10: `upd_c`, `upd_dc` and `upd_z` show the flags that the current op_code affects, as listed in R2, R3 and R5 to R7. These enables are independent of `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Allows the flag register to load this cycle |
| op_code | input | 4 | Operation select |
| src_sel | input | 2 | B operand source |
| w_data | input | 8 | Working register value |
| f_data | input | 8 | File-register value |
| lit_data | input | 8 | Immediate literal |
| result | output | 8 | Combinational result |
| upd_c | output | 1 | Carry update enable |
| upd_dc | output | 1 | Digit Carry update enable |
| upd_z | output | 1 | Zero update enable |
| flag_c | output | 1 | Stored Carry |
| flag_dc | output | 1 | Stored Digit Carry |
| flag_z | output | 1 | Stored Zero |

## Verification
The arithmetic operations are driven with operands chosen to separate the two carry chains:
- 0x0F + 0x01 gives a nibble carry without a byte carry.
- 0xFF + 0x01 gives both carries and a zero result.
- Equal operands in subtraction give both no-borrow flags and Z.
- 0x10 − 0x01 gives a nibble borrow only.
- 0x00 − 0x01 gives both borrows.

The rotates are run with the stored Carry at 0 and at 1, which shows whether the incoming bit comes from the flag. A long run of random operations, sources and valid strobes is then compared every clock against a behavioural model of the flag state. This catches any flag that is held or overwritten when it should not be.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_IOR  = 4'd3,
        OP_XOR  = 4'd4,
        OP_COM  = 4'd5,
        OP_PASS = 4'd6,
        OP_RLC  = 4'd7,
        OP_RRC  = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_FILE     = 2'd0,
        SRC_LIT      = 2'd1,
        SRC_W        = 2'd2,
        SRC_FILE_ALT = 2'd3
    } src_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flags_t;

endpackage

// File: rtl/alu8_src_mux.sv
module alu8_src_mux #(
    parameter int DATA_W = 8
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] w_val,
    input  logic [DATA_W-1:0] f_val,
    input  logic [DATA_W-1:0] lit_val,
    output logic [DATA_W-1:0] b_val
);
    import alu8_pkg::*;

    always_comb begin
        unique case (src_e'(sel))
            SRC_LIT:      b_val = lit_val;
            SRC_W:        b_val = w_val;
            SRC_FILE,
            SRC_FILE_ALT: b_val = f_val;
            default:      b_val = f_val;
        endcase
    end
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int DATA_W = 8,
    parameter int LO_W   = 4
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              c_out,
    output logic              dc_out
);
    localparam int HI_W = DATA_W - LO_W;

    logic [DATA_W-1:0] opb_x;
    logic [LO_W:0]     lo_sum;
    logic [HI_W:0]     hi_sum;

    always_comb begin
        opb_x  = sub ? ~opb : opb;
        lo_sum = {1'b0, opa[LO_W-1:0]} + {1'b0, opb_x[LO_W-1:0]}
                 + {{LO_W{1'b0}}, sub};
        hi_sum = {1'b0, opa[DATA_W-1:LO_W]} + {1'b0, opb_x[DATA_W-1:LO_W]}
                 + {{HI_W{1'b0}}, lo_sum[LO_W]};
        sum    = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
        c_out  = hi_sum[HI_W];
        dc_out = lo_sum[LO_W];
    end

    // R2/R3: the split nibble chain must agree with a full-width sum
    always_comb begin
        if ({c_out, sum} != ({1'b0, opa} + {1'b0, opb_x} + {{DATA_W{1'b0}}, sub}))
            assert_adder_chain_R2: assert (1'b0) else $error("adder chain mismatch");
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops #(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] w_val,
    input  logic [DATA_W-1:0] b_val,
    input  logic              c_in,
    output logic [DATA_W-1:0] res,
    output logic              c_rot
);
    import alu8_pkg::*;

    always_comb begin
        c_rot = c_in;
        unique case (alu_op_e'(op))
            OP_AND:  res = w_val & b_val;
            OP_IOR:  res = w_val | b_val;
            OP_XOR:  res = w_val ^ b_val;
            OP_COM:  res = ~b_val;
            OP_PASS: res = b_val;
            OP_RLC: begin
                res   = {b_val[DATA_W-2:0], c_in};
                c_rot = b_val[DATA_W-1];
            end
            OP_RRC: begin
                res   = {c_in, b_val[DATA_W-1:1]};
                c_rot = b_val[0];
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  alu8_pkg::flags_t upd,
    input  alu8_pkg::flags_t nxt,
    output alu8_pkg::flags_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            if (upd.c)  q.c  <= nxt.c;
            if (upd.dc) q.dc <= nxt.dc;
            if (upd.z)  q.z  <= nxt.z;
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [1:0]        src_sel,
    input  logic [DATA_W-1:0] w_data,
    input  logic [DATA_W-1:0] f_data,
    input  logic [DATA_W-1:0] lit_data,
    output logic [DATA_W-1:0] result,
    output logic              upd_c,
    output logic              upd_dc,
    output logic              upd_z,
    output logic              flag_c,
    output logic              flag_dc,
    output logic              flag_z
);
    import alu8_pkg::*;

    localparam int LO_W = DATA_W / 2;

    logic [DATA_W-1:0] b_val;
    logic [DATA_W-1:0] add_sum;
    logic              add_c;
    logic              add_dc;
    logic [DATA_W-1:0] bit_res;
    logic              rot_c;
    flags_t            upd_vec;
    flags_t            nxt_vec;
    flags_t            cur;

    alu8_src_mux #(.DATA_W(DATA_W)) u_src (
        .sel(src_sel), .w_val(w_data), .f_val(f_data),
        .lit_val(lit_data), .b_val(b_val)
    );

    alu8_adder #(.DATA_W(DATA_W), .LO_W(LO_W)) u_add (
        .opa(b_val), .opb(w_data), .sub(op_code == OP_SUB),
        .sum(add_sum), .c_out(add_c), .dc_out(add_dc)
    );

    alu8_bitops #(.DATA_W(DATA_W)) u_bit (
        .op(op_code), .w_val(w_data), .b_val(b_val),
        .c_in(cur.c), .res(bit_res), .c_rot(rot_c)
    );

    always_comb begin
        upd_vec = '0;
        nxt_vec = cur;
        result  = '0;
        unique case (alu_op_e'(op_code))
            OP_ADD, OP_SUB: begin
                result  = add_sum;
                upd_vec = '{c: 1'b1, dc: 1'b1, z: 1'b1};
                nxt_vec = '{c: add_c, dc: add_dc, z: (add_sum == '0)};
            end
            OP_AND, OP_IOR, OP_XOR, OP_COM, OP_PASS: begin
                result    = bit_res;
                upd_vec.z = 1'b1;
                nxt_vec.z = (bit_res == '0);
            end
            OP_RLC, OP_RRC: begin
                result    = bit_res;
                upd_vec.c = 1'b1;
                nxt_vec.c = rot_c;
            end
            default: begin
                result  = '0;
                upd_vec = '0;
            end
        endcase
    end

    alu8_flag_reg u_flags (
        .clk(clk), .rst_n(rst_n), .load(op_valid),
        .upd(upd_vec), .nxt(nxt_vec), .q(cur)
    );

    assign upd_c   = upd_vec.c;
    assign upd_dc  = upd_vec.dc;
    assign upd_z   = upd_vec.z;
    assign flag_c  = cur.c;
    assign flag_dc = cur.dc;
    assign flag_z  = cur.z;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!flag_c && !flag_dc && !flag_z))
        else $error("flags not cleared by reset");

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(flag_c) && $stable(flag_dc) && $stable(flag_z)))
        else $error("flags moved without op_valid");

    assert_zero_tracks_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && upd_z) |=> (flag_z == ($past(result) == '0)))
        else $error("Z does not follow result");

    assert_logic_keeps_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !upd_c && !upd_dc) |=> ($stable(flag_c) && $stable(flag_dc)))
        else $error("C or DC changed by non-arith op");

    assert_rotate_keeps_z_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_RLC || op_code == OP_RRC))
            |=> ($stable(flag_z) && $stable(flag_dc)))
        else $error("rotate touched DC or Z");

    assert_undef_no_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code > 4'd8) |-> (!upd_c && !upd_dc && !upd_z && result == '0))
        else $error("undefined op had effect");
endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [1:0] src_sel = '0;
    logic [7:0] w_data = '0, f_data = '0, lit_data = '0;
    logic [7:0] result;
    logic       upd_c, upd_dc, upd_z, flag_c, flag_dc, flag_z;

    int checks = 0;
    int errors = 0;
    int mc = 0, mdc = 0, mz = 0;
    bit done = 0;

    always #10 clk = ~clk;

    alu8_core i_alu8_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .src_sel(src_sel), .w_data(w_data), .f_data(f_data), .lit_data(lit_data),
        .result(result), .upd_c(upd_c), .upd_dc(upd_dc), .upd_z(upd_z),
        .flag_c(flag_c), .flag_dc(flag_dc), .flag_z(flag_z)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input int op, input int sel, input int w, input int f,
                       input int lit, input bit vld, input string req);
        int b, r, ec, edc, ez, uc, udc, uz, s;
        @(negedge clk);
        op_code = op[3:0]; src_sel = sel[1:0];
        w_data = w[7:0]; f_data = f[7:0]; lit_data = lit[7:0]; op_valid = vld;
        b = (sel == 1) ? lit : (sel == 2) ? w : f;
        r = 0; uc = 0; udc = 0; uz = 0; ec = mc; edc = mdc;
        case (op)
            0: begin s = b + w; r = s & 255; ec = (s >> 8) & 1;
                     edc = ((b & 15) + (w & 15)) >> 4; uc = 1; udc = 1; uz = 1; end
            1: begin s = b + ((~w) & 255) + 1; r = s & 255; ec = (s >> 8) & 1;
                     edc = ((b & 15) + ((~w) & 15) + 1) >> 4; uc = 1; udc = 1; uz = 1; end
            2: begin r = w & b; uz = 1; end
            3: begin r = w | b; uz = 1; end
            4: begin r = w ^ b; uz = 1; end
            5: begin r = (~b) & 255; uz = 1; end
            6: begin r = b; uz = 1; end
            7: begin r = ((b << 1) & 255) | mc; ec = (b >> 7) & 1; uc = 1; end
            8: begin r = (mc << 7) | (b >> 1); ec = b & 1; uc = 1; end
            default: r = 0;
        endcase
        ez = (r == 0) ? 1 : 0;
        #2;
        chk(req, "result", int'(result), r);
        chk("R10", "upd", int'({upd_c, upd_dc, upd_z}), (uc << 2) | (udc << 1) | uz);
        @(posedge clk);
        if (vld) begin
            if (uc) mc = ec;
            if (udc) mdc = edc;
            if (uz) mz = ez;
        end
        #1;
        chk(req, "flags", int'({flag_c, flag_dc, flag_z}), (mc << 2) | (mdc << 1) | mz);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "flags after reset", int'({flag_c, flag_dc, flag_z}), 0);
        @(negedge clk); rst_n = 1'b1;
        // R2 additions
        run(0, 0, 8'h01, 8'h0F, 0, 1, "R2");
        run(0, 1, 8'h01, 0, 8'hFF, 1, "R2");
        run(0, 0, 8'h70, 8'h20, 0, 1, "R2");
        // R3 subtractions
        run(1, 0, 8'h33, 8'h33, 0, 1, "R3");
        run(1, 1, 8'h01, 0, 8'h10, 1, "R3");
        run(1, 0, 8'h01, 8'h00, 0, 1, "R3");
        // R5/R6 logic and R4 zero
        run(2, 1, 8'hF0, 0, 8'h0F, 1, "R4");
        run(3, 0, 8'h50, 8'h0A, 0, 1, "R5");
        run(4, 2, 8'hA5, 0, 0, 1, "R5");
        run(5, 0, 0, 8'h3C, 0, 1, "R6");
        run(6, 1, 0, 0, 8'h00, 1, "R6");
        // R7 rotates with C=0 then C=1
        run(1, 0, 8'h01, 8'h00, 0, 1, "R3");
        run(7, 0, 0, 8'h81, 0, 1, "R7");
        run(7, 0, 0, 8'h01, 0, 1, "R7");
        run(8, 0, 0, 8'h02, 0, 1, "R7");
        run(8, 1, 0, 0, 8'h03, 1, "R7");
        // R8 source select code 3 and W
        run(6, 3, 8'h11, 8'h5A, 8'hC3, 1, "R8");
        run(6, 2, 8'h77, 8'h5A, 8'hC3, 1, "R8");
        // R9 undefined op and idle
        run(0, 0, 8'hFF, 8'h01, 0, 0, "R9");
        run(9, 0, 8'hFF, 8'h01, 0, 1, "R9");
        run(15, 1, 8'h12, 0, 8'h34, 1, "R9");
        for (int i = 0; i < 3000; i++)
            run($urandom % 16, $urandom % 4, $urandom & 255, $urandom & 255,
                $urandom & 255, ($urandom % 4) != 0, "R10");
        @(negedge clk); rst_n = 1'b0; mc = 0; mdc = 0; mz = 0;
        #2;
        chk("R1", "flags in reset", int'({flag_c, flag_dc, flag_z}), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule